// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block sequences the digital side of a dual-slope integrating analog-to-digital converter. The integrator, the comparator and the reference sit outside it. A start request powers up the analog section, holds the integrator in discharge for a short settle window, and then integrates the unknown input for a fixed count. Next it switches the integrator to the negative reference and times the run-down until the comparator drops. The run-down count is the conversion result.

A counter advances only on clock edges where the comparator reports high. The run-up phase ends when that counter wraps after 2^8 enabled edges. The counter is then cleared and reused to time the run-down. The final count goes into an output register, together with a held valid flag and a one-cycle done pulse. The analog supply enable is dropped whenever no conversion is running. A run-down that never ends saturates at full scale and raises an overrange flag.

Top module: `dual_slope_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, all outputs are 0, including result_o.
- R2: A start request in idle raises pwr_en_o at the next clock edge. pwr_en_o stays high until the edge that produces done_o and is low in idle.
- R3: For exactly SETTLE_CYC cycles after a start is accepted, int_rst_o is 1 and sel_ref_o is 0 (0 selects the input voltage).
- R4: During run-up, sel_ref_o is 0 and int_rst_o is 0. The phase lasts until 256 cycles with cmp_i high have been counted, and cycles with cmp_i low do not count. sel_ref_o then becomes 1 (1 selects the negative reference).
- R5: In run-down, result_o equals the number of run-down cycles with cmp_i high before the first cycle sampled with cmp_i low. A low first sample gives 0.
- R6: If cmp_i stays high for 256 run-down cycles, result_o is 255 and ovr_o is 1. Exactly 255 high cycles followed by a low sample gives 255 with ovr_o 0.
- R7: done_o pulses for one cycle when a result is latched, and valid_o rises with it. result_o, valid_o and ovr_o then hold until the next accepted start, which clears valid_o.
- R8: A start request while a conversion is running is ignored: the sequence does not restart and its timing is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion start request |
| cmp_i | input | 1 | Comparator result, high while integrator output is above threshold |
| sel_ref_o | output | 1 | Integrator input select: 0 input voltage, 1 negative reference |
| int_rst_o | output | 1 | Integrator discharge strobe |
| pwr_en_o | output | 1 | Analog section supply enable |
| result_o | output | 8 | Latched conversion result |
| valid_o | output | 1 | Result valid, held until the next start |
| ovr_o | output | 1 | Run-down overrange, result saturated |
| done_o | output | 1 | One-cycle pulse with each new result |

## Verification
Every output is registered, so pwr_en_o, int_rst_o and the cleared valid_o appear one edge after the start is accepted. int_rst_o then stays high for SETTLE_CYC cycles, and sel_ref_o rises 256 cycles later plus one cycle for each low comparator sample in run-up. done_o, result_o and ovr_o update at the edge that samples the first low comparator in run-down, or the 256th high one. The bench drives inputs and samples outputs on falling edges only. It counts falling edges in each phase and compares the counts and the latched values with these figures. It also checks on the falling edge after done_o that the pulse has ended.

// File: rtl/ds_pkg.sv
package ds_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETTLE  = 2'd1,
    ST_RUNUP   = 2'd2,
    ST_RUNDOWN = 2'd3
  } ds_state_e;
endpackage

// File: rtl/ds_counter.sv
module ds_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o,
  output logic         at_max_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + 1'b1;
  end

  assign at_max_o = (cnt_o == MAX);
endmodule

// File: rtl/ds_settle_timer.sv
module ds_settle_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int TW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(CYCLES - 1);

  logic [TW-1:0] tcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tcnt_q <= '0;
    else if (!run_i) tcnt_q <= '0;
    else if (!expire_o) tcnt_q <= tcnt_q + 1'b1;
  end

  // Last cycle of the settle window
  assign expire_o = run_i && (tcnt_q == LAST);
endmodule

// File: rtl/ds_result_latch.sv
module ds_result_latch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         sat_i,
  input  logic         clr_valid_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] result_o,
  output logic         valid_o,
  output logic         ovr_o,
  output logic         done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
      ovr_o    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= load_i;
      if (load_i) begin
        result_o <= sat_i ? {W{1'b1}} : cnt_i;
        ovr_o    <= sat_i;
        valid_o  <= 1'b1;
      end else if (clr_valid_i) begin
        valid_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dual_slope_ctrl.sv
module dual_slope_ctrl
  import ds_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int SETTLE_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             sel_ref_o,
  output logic             int_rst_o,
  output logic             pwr_en_o,
  output logic [CNT_W-1:0] result_o,
  output logic             valid_o,
  output logic             ovr_o,
  output logic             done_o
);
  ds_state_e state_q, state_d;

  logic [CNT_W-1:0] cnt;
  logic at_max, cnt_clr, cnt_en;
  logic settle_done, accept, wrap_up, stop_down, sat;

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign wrap_up   = (state_q == ST_RUNUP) && cmp_i && at_max;
  assign stop_down = (state_q == ST_RUNDOWN) && (!cmp_i || at_max);
  assign sat       = (state_q == ST_RUNDOWN) && cmp_i && at_max;

  // Count enable is the comparator gated by the active phase
  assign cnt_en  = cmp_i && ((state_q == ST_RUNUP) || (state_q == ST_RUNDOWN));
  assign cnt_clr = accept || wrap_up || stop_down;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i)     state_d = ST_SETTLE;
      ST_SETTLE:  if (settle_done) state_d = ST_RUNUP;
      ST_RUNUP:   if (wrap_up)     state_d = ST_RUNDOWN;
      ST_RUNDOWN: if (stop_down)   state_d = ST_IDLE;
      default:                     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign pwr_en_o  = (state_q != ST_IDLE);
  assign int_rst_o = (state_q == ST_SETTLE);
  assign sel_ref_o = (state_q == ST_RUNDOWN);

  ds_settle_timer #(.CYCLES(SETTLE_CYC)) u_settle (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == ST_SETTLE),
    .expire_o (settle_done)
  );

  ds_counter #(.W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cnt_clr),
    .en_i     (cnt_en),
    .cnt_o    (cnt),
    .at_max_o (at_max)
  );

  ds_result_latch #(.W(CNT_W)) u_res (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (stop_down),
    .sat_i       (sat),
    .clr_valid_i (accept),
    .cnt_i       (cnt),
    .result_o    (result_o),
    .valid_o     (valid_o),
    .ovr_o       (ovr_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/ds_ctrl_checker.sv
module ds_ctrl_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             cmp_i,
  input logic             sel_ref_o,
  input logic             int_rst_o,
  input logic             pwr_en_o,
  input logic [CNT_W-1:0] result_o,
  input logic             valid_o,
  input logic             ovr_o,
  input logic             done_o
);
  p_pwr_off_at_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !pwr_en_o);

  p_settle_on_input_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rst_o |-> (!sel_ref_o && pwr_en_o));

  p_ref_after_count_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_ref_o) |-> $past(cmp_i));

  p_ovr_full_scale_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> (result_o == {CNT_W{1'b1}}));

  p_done_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> valid_o);

  p_result_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  p_no_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_en_o && !int_rst_o) |=> !int_rst_o);
endmodule

bind dual_slope_ctrl ds_ctrl_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .cmp_i     (cmp_i),
  .sel_ref_o (sel_ref_o),
  .int_rst_o (int_rst_o),
  .pwr_en_o  (pwr_en_o),
  .result_o  (result_o),
  .valid_o   (valid_o),
  .ovr_o     (ovr_o),
  .done_o    (done_o)
);

// File: tb/dual_slope_ctrl_test.sv
`timescale 1ns/1ps
module dual_slope_ctrl_test;
  localparam int SETTLE = 4;
  localparam int RUNUP  = 256;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic cmp_i = 1'b0;
  logic sel_ref_o, int_rst_o, pwr_en_o, valid_o, ovr_o, done_o;
  logic [7:0] result_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  dual_slope_ctrl #(.CNT_W(8), .SETTLE_CYC(SETTLE)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .cmp_i(cmp_i),
    .sel_ref_o(sel_ref_o), .int_rst_o(int_rst_o), .pwr_en_o(pwr_en_o),
    .result_o(result_o), .valid_o(valid_o), .ovr_o(ovr_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // One conversion: gap low cycles at start of run-up, k high cycles in run-down
  task automatic run_conv(input int k, input int gap, input bit poke_start);
    int n;
    int exp_res;
    @(negedge clk); start_i = 1'b1; cmp_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(pwr_en_o == 1'b1, "R2 pwr on after start", pwr_en_o, 1);
    chk(valid_o == 1'b0, "R7 valid cleared by start", valid_o, 0);
    n = 0;
    while (int_rst_o && n < 100) begin
      if (sel_ref_o) chk(1'b0, "R3 ref during settle", 1, 0);
      n++; @(negedge clk);
    end
    chk(n == SETTLE, "R3 settle length", n, SETTLE);
    n = 0;
    while (!sel_ref_o && n < 1000) begin
      n++;
      cmp_i   = (n > gap);
      start_i = poke_start && (n == 5);
      @(negedge clk);
      start_i = 1'b0;
      if (int_rst_o) chk(1'b0, "R8 restart during run-up", 1, 0);
    end
    chk(n == RUNUP + gap, "R4 run-up length", n, RUNUP + gap);
    n = 0;
    while (!done_o && n < 1000) begin
      cmp_i = (n < k);
      start_i = poke_start && (n == 3);
      n++;
      @(negedge clk);
      start_i = 1'b0;
      chk(pwr_en_o == !done_o, "R2 pwr tracks activity", pwr_en_o, !done_o);
    end
    exp_res = (k > 255) ? 255 : k;
    chk(result_o == 8'(exp_res), (k > 255) ? "R6 saturated result" : "R5 run-down result",
        result_o, exp_res);
    chk(ovr_o == (k > 255), "R6 overrange flag", ovr_o, k > 255);
    chk(valid_o == 1'b1, "R7 valid with done", valid_o, 1);
    cmp_i = 1'b0;
    @(negedge clk);
    chk(done_o == 1'b0, "R7 done single cycle", done_o, 0);
    chk(result_o == 8'(exp_res), "R7 result held", result_o, exp_res);
    chk(pwr_en_o == 1'b0 && sel_ref_o == 1'b0, "R2 idle power off", pwr_en_o, 0);
  endtask

  task automatic t_reset;
    chk(pwr_en_o == 0 && int_rst_o == 0 && sel_ref_o == 0, "R1 controls in reset",
        {pwr_en_o, int_rst_o, sel_ref_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(result_o == 0 && valid_o == 0 && ovr_o == 0 && done_o == 0, "R1 result after reset",
        {result_o, valid_o, ovr_o, done_o}, 0);
  endtask

  task automatic t_idle_hold;
    int r;
    r = result_o;
    repeat (10) @(negedge clk);
    chk(result_o == 8'(r) && valid_o == 1'b1, "R7 hold in idle", result_o, r);
    chk(pwr_en_o == 1'b0, "R2 off while idle", pwr_en_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    run_conv(100, 0, 1'b0);   // R5 mid-scale
    t_idle_hold();
    run_conv(0, 0, 1'b0);     // R5 immediate low
    run_conv(37, 10, 1'b0);   // R4 gated counting
    run_conv(255, 0, 1'b0);   // R6 exact full scale, no overrange
    run_conv(300, 0, 1'b0);   // R6 saturation
    run_conv(60, 3, 1'b1);    // R8 start ignored while busy
    run_conv(1, 0, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule